// File: doc/BRIEF.md
# Two-Bit Chainable Arithmetic Slice

This block is a 2-bit arithmetic cell meant to be tiled into wider datapaths. A three-bit operation code picks what the cell does with its two operands and its carry-in. It can add, subtract, add or subtract under a per-cycle control bit, count up or down in a small internal register, or compare its operands. Three relations are available: greater-or-equal, not-equal and less-or-equal.

Every slice drives a carry-out and a pair of group signals, generate and propagate. When a wrapper connects each slice's carry-out to the next slice's carry-in, the slices form a ripple datapath of any even width. The group signals let a wrapper compute the carries for many slices at once, without waiting for the ripple.

Subtraction adds the inverted B operand. The wrapper must drive a carry-in of 1 into the lowest slice, and a carry-out of 1 then means that no borrow occurred. The greater-or-equal and less-or-equal compares also need a carry-in of 1 at the lowest slice. Not-equal needs a carry-in of 0 there. For counting, the lowest slice's carry-in is the step enable, and each carry-out feeds the next slice's carry-in.

Top module: `rslice_top`

## Requirements
- R1: With mode 0 (add), {cout, result} equals a + b + cin.
- R2: With mode 1 (subtract), {cout, result} equals a + (~b) + cin. With cin = 1 this gives a − b modulo 4, and cout = 1 exactly when a ≥ b.
- R3: With mode 2 (dynamic add/subtract), the slice behaves as mode 0 when addSub = 0 and as mode 1 when addSub = 1.
- R4: With mode 3 (up count), result shows the count register. cout equals cin AND (count == 3). On a clock edge where cntEn = 1, the count becomes count + cin modulo 4.
- R5: With mode 4 (down count), result shows the count register. cout (borrow) equals cin AND (count == 0). On a clock edge where cntEn = 1, the count becomes count − cin modulo 4.
- R6: The count register keeps its value on every edge where cntEn = 0 or the mode is neither 3 nor 4.
- R7: With mode 5 (greater-or-equal), cout = (a > b) OR (a == b AND cin), and result = {0, cout}.
- R8: With mode 6 (not-equal), cout = (a != b) OR cin, and result = {0, cout}.
- R9: With mode 7 (less-or-equal), cout = (a < b) OR (a == b AND cin), and result = {0, cout}.
- R10: In every mode, cout = gen OR (prop AND cin), and gen and prop do not depend on cin. gen is the carry-out the slice would give with cin = 0. prop is 1 exactly when cin would change cout.
- R11: After reset (rstN low), the count register is 0.
- R12: Slices chained carry-out to carry-in form a wider unit. Add, subtract, the three compares, and both counters then work across the full width, with the top slice's cout as the overall carry, borrow or compare result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the count register |
| rstN | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Operation code (0 add, 1 sub, 2 add/sub, 3 up, 4 down, 5 ge, 6 ne, 7 le) |
| addSub | input | 1 | In mode 2: 0 adds, 1 subtracts |
| cntEn | input | 1 | Allows the count register to update in modes 3 and 4 |
| a | input | WIDTH (2) | Operand A |
| b | input | WIDTH (2) | Operand B |
| cin | input | 1 | Carry, borrow or compare input from the lower slice |
| result | output | WIDTH (2) | Sum, count value or compare flag |
| cout | output | 1 | Carry, borrow or compare output to the upper slice |
| gen | output | 1 | Group carry-generate |
| prop | output | 1 | Group carry-propagate |

## Verification
The assertions check, on every cycle, that cout agrees with gen and prop. They also check each step of the count register: it holds when no update is allowed and moves by exactly cin in the selected direction when one is. They further check that a compare leaves the upper result bits at zero, and that the control never asks for two operand sources at once. Only the bench's scenarios can show that each operation gives the right arithmetic value. These are a sweep over every operand and carry combination of one slice, and wide add, subtract and compare sweeps plus long count runs on a four-slice chain. The chain runs also show that carries rippling from slice to slice give the correct wide result.

// File: rtl/rslice_pkg.sv
package rslice_pkg;

  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_SUB    = 3'd1,
    OP_ADDSUB = 3'd2,
    OP_UP     = 3'd3,
    OP_DOWN   = 3'd4,
    OP_GE     = 3'd5,
    OP_NE     = 3'd6,
    OP_LE     = 3'd7
  } opMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic useCnt;   // operand A comes from the count register
    logic swapAB;   // exchange operands (less-or-equal)
    logic invA;     // invert operand A before the adder
    logic invB;     // invert operand B before the adder
    logic zeroB;    // force operand B to zero
    logic invSum;   // invert the adder sum
    logic neChain;  // not-equal carry chain instead of adder carry
    logic cmpOut;   // result shows the compare flag
    logic cntLoad;  // count register takes the sum this edge
  } sliceCtrl_t;

endpackage

// File: rtl/rslice_ctrl.sv
module rslice_ctrl
  import rslice_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       addSub,
  input  logic       cntEn,
  output sliceCtrl_t ctrl
);

  opMode_e opSel;
  assign opSel = opMode_e'(mode);

  always_comb begin
    ctrl = '0;
    unique case (opSel)
      OP_ADD:    ;
      OP_SUB:    ctrl.invB = 1'b1;
      OP_ADDSUB: ctrl.invB = addSub;
      OP_UP: begin
        ctrl.useCnt  = 1'b1;
        ctrl.zeroB   = 1'b1;
        ctrl.cntLoad = cntEn;
      end
      OP_DOWN: begin
        // count - cin computed as ~(~count + cin)
        ctrl.useCnt  = 1'b1;
        ctrl.zeroB   = 1'b1;
        ctrl.invA    = 1'b1;
        ctrl.invSum  = 1'b1;
        ctrl.cntLoad = cntEn;
      end
      OP_GE: begin
        ctrl.invB   = 1'b1;
        ctrl.cmpOut = 1'b1;
      end
      OP_NE: begin
        ctrl.neChain = 1'b1;
        ctrl.cmpOut  = 1'b1;
      end
      OP_LE: begin
        ctrl.swapAB = 1'b1;
        ctrl.invB   = 1'b1;
        ctrl.cmpOut = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rslice_dp.sv
module rslice_dp
  import rslice_pkg::*;
#(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  sliceCtrl_t       ctrl,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] result,
  output logic             cout,
  output logic             gen,
  output logic             prop
);

  localparam logic [WIDTH-1:0] ZERO_W = '0;

  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] srcA, srcB, opA, opB;
  logic [WIDTH-1:0] pBit, gBit, sumRaw, sumOut;
  logic [WIDTH:0]   carry;
  logic             gAcc, pAcc, neAny;
  logic [WIDTH-1:0] cinExt;

  assign cinExt = {{(WIDTH-1){1'b0}}, cin};

  // operand selection and conditioning
  assign srcA = ctrl.useCnt ? cnt : (ctrl.swapAB ? b : a);
  assign srcB = ctrl.swapAB ? a : b;
  assign opA  = ctrl.invA ? ~srcA : srcA;
  assign opB  = ctrl.zeroB ? ZERO_W : (ctrl.invB ? ~srcB : srcB);

  assign pBit = opA ^ opB;
  assign gBit = opA & opB;

  // bitwise ripple inside the slice
  assign carry[0] = cin;
  for (genvar i = 0; i < WIDTH; i++) begin : g_ripple
    assign carry[i+1] = gBit[i] | (pBit[i] & carry[i]);
    assign sumRaw[i]  = pBit[i] ^ carry[i];
  end

  assign sumOut = ctrl.invSum ? ~sumRaw : sumRaw;

  // group generate / propagate, independent of cin
  always_comb begin
    gAcc = 1'b0;
    pAcc = 1'b1;
    for (int i = 0; i < WIDTH; i++) begin
      gAcc = gBit[i] | (pBit[i] & gAcc);
      pAcc = pAcc & pBit[i];
    end
  end

  assign neAny = |(a ^ b);

  assign gen  = ctrl.neChain ? neAny  : gAcc;
  assign prop = ctrl.neChain ? ~neAny : pAcc;
  assign cout = ctrl.neChain ? (neAny | cin) : carry[WIDTH];

  always_comb begin
    if (ctrl.useCnt)      result = cnt;
    else if (ctrl.cmpOut) result = {{(WIDTH-1){1'b0}}, cout};
    else                  result = sumOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (ctrl.cntLoad) cnt <= sumOut;
  end

  // R10: carry-out consistent with exported group signals
  p_gp_consistent_r10: assert property (@(posedge clk) disable iff (!rstN)
    cout == (gen | (prop & cin)));

  // R6: count holds without a load strobe
  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.cntLoad |=> cnt == $past(cnt));

  // R4: up count steps by cin
  p_cnt_up_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.cntLoad && !ctrl.invSum) |=> cnt == WIDTH'($past(cnt) + $past(cinExt)));

  // R5: down count steps by cin
  p_cnt_down_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.cntLoad && ctrl.invSum) |=> cnt == WIDTH'($past(cnt) - $past(cinExt)));

  // R7: compare leaves upper result bits clear
  p_cmp_upper_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.cmpOut |-> result[WIDTH-1:1] == '0);

  // R3: at most one operand source override
  p_src_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.useCnt, ctrl.swapAB, ctrl.neChain}));

endmodule

// File: rtl/rslice_top.sv
module rslice_top
  import rslice_pkg::*;
#(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       mode,
  input  logic             addSub,
  input  logic             cntEn,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] result,
  output logic             cout,
  output logic             gen,
  output logic             prop
);

  sliceCtrl_t ctrl;

  rslice_ctrl ctrl_i (
    .mode   (mode),
    .addSub (addSub),
    .cntEn  (cntEn),
    .ctrl   (ctrl)
  );

  rslice_dp #(.WIDTH(WIDTH)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .a      (a),
    .b      (b),
    .cin    (cin),
    .result (result),
    .cout   (cout),
    .gen    (gen),
    .prop   (prop)
  );

endmodule

// File: tb/rslice_top_tb_top.sv
`timescale 1ns/100ps
module rslice_top_tb_top;

  localparam int NSL = 4;
  localparam int WW  = 2 * NSL;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] mode = '0;
  logic addSub = 1'b0, cntEn = 1'b0;
  logic [1:0] a = '0, b = '0;
  logic cin = 1'b0;
  logic [1:0] result;
  logic cout, gen, prop;

  logic [WW-1:0]  wa = '0, wb = '0;
  logic [NSL:0]   cw;
  logic [WW-1:0]  wres;
  logic [NSL-1:0] wgen, wprop;
  logic           chainCin = 1'b0;

  int checks = 0;
  int errs = 0;

  always #2.5 clk = ~clk;

  rslice_top dut_i (
    .clk(clk), .rstN(rstN), .mode(mode), .addSub(addSub), .cntEn(cntEn),
    .a(a), .b(b), .cin(cin), .result(result), .cout(cout), .gen(gen), .prop(prop)
  );

  assign cw[0] = chainCin;
  for (genvar k = 0; k < NSL; k++) begin : chain_g
    rslice_top slice_i (
      .clk(clk), .rstN(rstN), .mode(mode), .addSub(addSub), .cntEn(cntEn),
      .a(wa[2*k +: 2]), .b(wb[2*k +: 2]), .cin(cw[k]),
      .result(wres[2*k +: 2]), .cout(cw[k+1]), .gen(wgen[k]), .prop(wprop[k])
    );
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expCout(int m, bit as, int x, int y, bit c);
    int s;
    case (m)
      0: s = x + y + c;
      1: s = x + (3 - y) + c;
      2: s = as ? x + (3 - y) + c : x + y + c;
      5: return (x > y) || (x == y && c);
      6: return (x != y) || c;
      default: return (x < y) || (x == y && c);
    endcase
    return s >= 4;
  endfunction

  function automatic int expRes(int m, bit as, int x, int y, bit c);
    if (m >= 5) return int'(expCout(m, as, x, y, c));
    if (m == 0 || (m == 2 && !as)) return (x + y + c) % 4;
    return (x + (3 - y) + c) % 4;
  endfunction

  function automatic string tagOf(int m, bit as);
    case (m)
      0: return "R1 add";
      1: return "R2 sub";
      2: return as ? "R3 addsub=1" : "R3 addsub=0";
      5: return "R7 ge";
      6: return "R8 ne";
      default: return "R9 le";
    endcase
  endfunction

  // carry into the top computed from the group signals only
  function automatic bit lookCarry(logic [NSL-1:0] g, logic [NSL-1:0] p, bit c0);
    bit c = c0;
    for (int k = 0; k < NSL; k++) c = g[k] | (p[k] & c);
    return c;
  endfunction

  initial begin : watchdog
    #(5.0 * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog expired, run incomplete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin : stim
    int expCnt;
    int expW;
    repeat (3) @(negedge clk);
    // R11: reset state visible through up-count result
    mode = 3'd3;
    #1 chk(result == 2'd0, "R11 reset count", result, 0);
    chk(wres == '0, "R11 reset wide count", wres, 0);
    rstN = 1'b1;
    @(negedge clk);

    // single slice exhaustive sweep of combinational modes
    for (int m = 0; m < 8; m++) begin
      if (m == 3 || m == 4) continue;
      for (int as = 0; as < 2; as++) begin
        if (m != 2 && as == 1) continue;
        for (int x = 0; x < 4; x++)
          for (int y = 0; y < 4; y++)
            for (int c = 0; c < 2; c++) begin
              bit c0, c1, eg, ep;
              mode = 3'(m); addSub = as[0]; a = 2'(x); b = 2'(y); cin = c[0];
              #1;
              c0 = expCout(m, as[0], x, y, 1'b0);
              c1 = expCout(m, as[0], x, y, 1'b1);
              eg = c0; ep = (c0 != c1);
              chk({result, cout} == {2'(expRes(m, as[0], x, y, c[0])), expCout(m, as[0], x, y, c[0])},
                  tagOf(m, as[0]), {result, cout},
                  {2'(expRes(m, as[0], x, y, c[0])), expCout(m, as[0], x, y, c[0])});
              chk({gen, prop} == {eg, ep}, "R10 gen/prop", {gen, prop}, {eg, ep});
            end
      end
    end

    // single slice up count, R4
    mode = 3'd3; addSub = 0; cin = 1; cntEn = 1;
    expCnt = 0;
    for (int i = 0; i < 6; i++) begin
      #1 chk(cout == (expCnt == 3), "R4 up carry", cout, expCnt == 3);
      @(posedge clk); @(negedge clk);
      expCnt = (expCnt + 1) % 4;
      chk(result == 2'(expCnt), "R4 up count", result, expCnt);
    end
    // R6: hold with enable low, cin low step, and foreign mode
    cntEn = 0;
    repeat (2) @(negedge clk);
    chk(result == 2'(expCnt), "R6 hold cntEn=0", result, expCnt);
    cntEn = 1; cin = 0;
    repeat (2) @(negedge clk);
    chk(result == 2'(expCnt), "R4 cin=0 no step", result, expCnt);
    cin = 1; mode = 3'd0; a = 2'd3; b = 2'd3;
    repeat (2) @(negedge clk);
    mode = 3'd3; cntEn = 0;
    #1 chk(result == 2'(expCnt), "R6 hold in add mode", result, expCnt);
    @(negedge clk);

    // single slice down count, R5
    mode = 3'd4; cntEn = 1; cin = 1;
    for (int i = 0; i < 6; i++) begin
      #1 chk(cout == (expCnt == 0), "R5 down borrow", cout, expCnt == 0);
      @(posedge clk); @(negedge clk);
      expCnt = (expCnt + 3) % 4;
      chk(result == 2'(expCnt), "R5 down count", result, expCnt);
    end
    cntEn = 0;
    @(negedge clk);

    // wide chain sweeps, R12
    for (int x = 0; x < 256; x += 5)
      for (int y = 0; y < 256; y += 7)
        for (int m = 0; m < 8; m++) begin
          bit ec;
          int er;
          if (m == 2 || m == 3 || m == 4) continue;
          mode = 3'(m); wa = WW'(x); wb = WW'(y);
          chainCin = (m == 1 || m == 5 || m == 7);
          case (m)
            0: begin er = (x + y) % 256; ec = (x + y) >= 256; end
            1: begin er = (x - y + 256) % 256; ec = x >= y; end
            5: begin ec = x >= y; er = -1; end
            6: begin ec = x != y; er = -1; end
            default: begin ec = x <= y; er = -1; end
          endcase
          #1;
          chk(cw[NSL] == ec, "R12 wide carry/compare", cw[NSL], ec);
          if (er >= 0) chk(wres == WW'(er), "R12 wide sum", wres, er);
          chk(lookCarry(wgen, wprop, chainCin) == cw[NSL], "R10 lookahead carry",
              lookCarry(wgen, wprop, chainCin), cw[NSL]);
        end

    // wide counters, R12
    @(negedge clk);
    expW = 0;
    // current wide count unknown after single tests? chain was untouched: still 0
    mode = 3'd3; chainCin = 1; cntEn = 1;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); @(negedge clk);
      expW = (expW + 1) % 256;
      chk(wres == WW'(expW), "R12 wide up count", wres, expW);
    end
    mode = 3'd4;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); @(negedge clk);
      expW = (expW + 255) % 256;
      chk(wres == WW'(expW), "R12 wide down count", wres, expW);
    end
    cntEn = 0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

endmodule